// File: doc/BRIEF.md
# Serial register configuration port

This block is the slave end of a four-wire serial link that a host uses to read and write 16-bit registers inside a video interface FPGA. The host supplies the serial clock, a one-cycle frame sync pulse and a downstream data line. The block sends read data back on a separate upstream line. All four signals are single-ended and are sampled on the rising edge of the serial clock. In this design the serial clock is the block clock `clk`.

Every frame has 32 bits. The first 16 are the address, sent MSB first, and the address MSB is the direction flag (1 = read, 0 = write). The next 16 bits are the data field, also MSB first. A completed write frame updates a 16-entry internal register file and raises a one-cycle write strobe, with the full address and data, towards the rest of the chip. For a read frame, the selected register is shifted back to the host during the data-field bit times.

A state machine with three states controls the frame:
- `ST_IDLE` waits for sync.
- `ST_ADDR` collects the address bits.
- `ST_DATA` collects the data bits.

Its transitions are:
- IDLE to ADDR when sync is seen.
- ADDR to ADDR or DATA to ADDR when a new sync arrives mid-frame (the frame restarts).
- ADDR to DATA after the 16th address bit.
- DATA to IDLE after the 32nd bit.

Top module: `sport_cfg_port`

## Requirements
- R1: After reset, `sdout_o`, `wr_stb_o`, `wr_addr_o` and `wr_data_o` are 0, and all 16 internal registers read back as 0.
- R2: The first frame bit is sampled on the rising edge after the one at which `sync_i` is seen high. Frame bit n (n = 0..31) is sampled n+1 edges after sync. Bits 0..15 are address[15:0] MSB first and bits 16..31 are data[15:0] MSB first.
- R3: A complete frame with address bit 15 = 0 is a write. `wr_stb_o` is high for exactly the one cycle after the edge that samples bit 31, with `wr_addr_o` and `wr_data_o` equal to the frame's address and data. At no other time is it high.
- R4: The register file is selected by address bits 3:0 only. Address bits 14:4 do not affect which register is written or read.
- R5: For a read frame (address bit 15 = 1), after the edge that samples bit 15+j (j = 0..15), `sdout_o` holds bit 15-j of the selected register. The host therefore samples register bit 15-j on the edge that samples data bit j.
- R6: `sdout_o` is 0 at all other times: during idle, in the address field, for the whole of a write frame, and after the last bit of a read frame.
- R7: A read frame produces no write strobe and changes no register, whatever the host sends in its data field.
- R8: A sync seen before bit 31 has been sampled discards the frame in progress. There is no strobe and no register change, and a new frame starts from that sync.
- R9: A sync on the edge where bit 31 would be sampled also discards the frame. This sync wins over completion.
- R10: Data-line activity with no sync while idle has no effect on `sdout_o`, `wr_stb_o` or any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock from the host; all sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync pulse, one clock wide |
| sdin_i | input | 1 | Host-to-slave serial data |
| sdout_o | output | 1 | Slave-to-host serial read data |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 16 | Address of the last completed write |
| wr_data_o | output | 16 | Data of the last completed write |

## Verification
Two events can fall on the same clock edge:
- the sampling of a frame's final bit, which would fire the write strobe and commit the register;
- a fresh sync pulse, which must cancel that frame.

The bench provokes this by raising sync in place of bit 31 of a write frame, and also in place of earlier bits of both write and read frames. It judges the outcome in three ways: the strobe stays low through the whole frame, the return line falls to 0 after the sync, and a later read of the targeted register still shows the value it had before the cut frame.

// File: rtl/sport_pkg.sv
package sport_pkg;

    // Frame progress of the serial configuration port.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } sport_state_e;

endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
    import sport_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic bit_en_o,
    output logic addr_last_o,
    output logic data_last_o
);

    localparam int unsigned FW = AW + DW;
    localparam int unsigned CW = $clog2(FW);

    sport_state_e   state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        bit_en_o    = 1'b0;
        addr_last_o = 1'b0;
        data_last_o = 1'b0;
        if (sync_i) begin
            // any state: a sync (re)starts the frame
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_ADDR: begin
                    bit_en_o = 1'b1;
                    cnt_d    = cnt_q + CW'(1);
                    if (cnt_q == CW'(AW - 1)) begin
                        addr_last_o = 1'b1;
                        state_d     = ST_DATA;
                    end
                end
                ST_DATA: begin
                    bit_en_o = 1'b1;
                    if (cnt_q == CW'(FW - 1)) begin
                        data_last_o = 1'b1;
                        state_d     = ST_IDLE;
                        cnt_d       = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sport_shift.sv
module sport_shift #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             sdin_i,
    input  logic             bit_en_i,
    input  logic             addr_last_i,
    input  logic             data_last_i,
    input  logic [DW-1:0]    rd_val_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             we_o,
    output logic [IDX_W-1:0] widx_o,
    output logic [DW-1:0]    wdata_o,
    output logic             sdout_o,
    output logic             wr_stb_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic [DW-1:0]    wr_data_o
);

    localparam int unsigned FW = AW + DW;

    logic [FW-2:0] rx_q;
    logic [FW-1:0] frame_w;
    logic [DW-1:0] tx_q;
    logic          is_read;

    // the bit sampled on this edge joins the bits already shifted in
    assign frame_w  = {rx_q, sdin_i};
    assign rd_idx_o = frame_w[IDX_W-1:0];
    assign is_read  = frame_w[AW-1];
    assign we_o     = data_last_i & ~frame_w[FW-1];
    assign widx_o   = frame_w[DW+IDX_W-1:DW];
    assign wdata_o  = frame_w[DW-1:0];
    assign sdout_o  = tx_q[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (bit_en_i) begin
            rx_q <= frame_w[FW-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (sync_i) begin
            tx_q <= '0;
        end else if (addr_last_i) begin
            tx_q <= is_read ? rd_val_i : '0;
        end else if (bit_en_i) begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o <= we_o;
            if (we_o) begin
                wr_addr_o <= frame_w[FW-1:DW];
                wr_data_o <= frame_w[DW-1:0];
            end
        end
    end

endmodule

// File: rtl/sport_regs.sv
module sport_regs #(
    parameter int unsigned DW    = 16,
    parameter int unsigned REG_N = 16,
    parameter int unsigned IDX_W = $clog2(REG_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [DW-1:0]    rdata_o
);

    logic [DW-1:0] word_q [REG_N];

    for (genvar g = 0; g < REG_N; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (we_i && (widx_i == IDX_W'(g))) begin
                word_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = word_q[ridx_i];

endmodule

// File: rtl/sport_cfg_port.sv
module sport_cfg_port #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned REG_N = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          sdin_i,
    output logic          sdout_o,
    output logic          wr_stb_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    localparam int unsigned IDX_W = $clog2(REG_N);

    logic             bit_en, addr_last, data_last;
    logic             we;
    logic [IDX_W-1:0] widx, ridx;
    logic [DW-1:0]    wdata, rdata;

    sport_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .bit_en_o    (bit_en),
        .addr_last_o (addr_last),
        .data_last_o (data_last)
    );

    sport_shift #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .sdin_i      (sdin_i),
        .bit_en_i    (bit_en),
        .addr_last_i (addr_last),
        .data_last_i (data_last),
        .rd_val_i    (rdata),
        .rd_idx_o    (ridx),
        .we_o        (we),
        .widx_o      (widx),
        .wdata_o     (wdata),
        .sdout_o     (sdout_o),
        .wr_stb_o    (wr_stb_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

    sport_regs #(.DW(DW), .REG_N(REG_N), .IDX_W(IDX_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .widx_i  (widx),
        .wdata_i (wdata),
        .ridx_i  (ridx),
        .rdata_o (rdata)
    );

endmodule

// File: rtl/sport_cfg_port_chk.sv
module sport_cfg_port_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_i,
    input logic          sdout_o,
    input logic          wr_stb_o,
    input logic [AW-1:0] wr_addr_o
);

    localparam int unsigned FW = AW + DW;
    localparam int unsigned CW = $clog2(FW);

    // independent frame tracker: bits sampled since the last sync
    logic          act_q;
    logic [CW-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            bits_q <= '0;
        end else if (sync_i) begin
            act_q  <= 1'b1;
            bits_q <= '0;
        end else if (act_q) begin
            if (bits_q == CW'(FW - 1)) begin
                act_q  <= 1'b0;
                bits_q <= '0;
            end else begin
                bits_q <= bits_q + CW'(1);
            end
        end
    end

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R3
    stb_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ($past(act_q) && ($past(bits_q) == CW'(FW - 1)) && !$past(sync_i)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> !sdout_o);

    // R6
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && (bits_q < CW'(AW))) |-> !sdout_o);

    // R7
    stb_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !wr_addr_o[AW-1]);

    // R8
    sync_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> !wr_stb_o);

endmodule

bind sport_cfg_port sport_cfg_port_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .sdout_o   (sdout_o),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o)
);

// File: tb/sport_cfg_port_tb.sv
module sport_cfg_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sync_i;
    logic        sdin_i;
    logic        sdout_o;
    logic        wr_stb_o;
    logic [15:0] wr_addr_o;
    logic [15:0] wr_data_o;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [15:0] model [16];

    always #2 clk = ~clk;

    sport_cfg_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_i),
        .sdin_i    (sdin_i),
        .sdout_o   (sdout_o),
        .wr_stb_o  (wr_stb_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One frame. cut >= 0 replaces bit 'cut' by a new sync and returns.
    // presync = 1: sync was already raised by the previous cut frame.
    task automatic frame(input logic [15:0] a, input logic [15:0] d, input int cut,
                         input bit presync, input string tag, input string stag);
        logic [31:0] fw;
        logic [15:0] exp_rd;
        bit          rd;
        fw     = {a, d};
        rd     = a[15];
        exp_rd = model[a[3:0]];
        if (!presync) begin
            @(negedge clk);
            chk(sdout_o == 1'b0, "R6", 32'(sdout_o), 32'd0);
            sync_i = 1'b1;
            sdin_i = 1'b0;
        end
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (i >= 16 && rd)
                chk(sdout_o == exp_rd[31-i], tag, 32'(sdout_o), 32'(exp_rd[31-i]));
            else
                chk(sdout_o == 1'b0, "R6", 32'(sdout_o), 32'd0);
            chk(wr_stb_o == 1'b0, stag, 32'(wr_stb_o), 32'd0);
            if (i == cut) begin
                sync_i = 1'b1;
                sdin_i = 1'b0;
                return;
            end
            sync_i = 1'b0;
            sdin_i = fw[31-i];
        end
        @(negedge clk);
        sync_i = 1'b0;
        sdin_i = 1'b0;
        chk(sdout_o == 1'b0, "R6", 32'(sdout_o), 32'd0);
        chk(wr_stb_o == !rd, rd ? "R7" : "R3", 32'(wr_stb_o), 32'(!rd));
        if (!rd) begin
            chk(wr_addr_o == a, "R3", 32'(wr_addr_o), 32'(a));
            chk(wr_data_o == d, "R3", 32'(wr_data_o), 32'(d));
            model[a[3:0]] = d;
        end
        @(negedge clk);
        chk(wr_stb_o == 1'b0, "R3", 32'(wr_stb_o), 32'd0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) model[k] = 16'h0;
        rst_n  = 1'b0;
        sync_i = 1'b0;
        sdin_i = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sdout_o == 1'b0, "R1", 32'(sdout_o), 32'd0);
        chk(wr_stb_o == 1'b0, "R1", 32'(wr_stb_o), 32'd0);
        chk(wr_addr_o == 16'h0, "R1", 32'(wr_addr_o), 32'd0);
        chk(wr_data_o == 16'h0, "R1", 32'(wr_data_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads as zero after reset (read data field is junk, R7)
        for (int k = 0; k < 16; k++)
            frame(16'h8000 | 16'(k * 16'h0130) | 16'(k), 16'hFFFF, -1, 1'b0, "R1", "R7");

        // R3/R4: write every register with varied upper address bits
        for (int k = 0; k < 16; k++)
            frame({1'b0, 11'(k * 97 + 3), 4'(k)}, 16'(k * 16'h1357) ^ 16'hC3A5, -1, 1'b0, "R3", "R3");

        // R4: read back with different upper address bits (aliasing)
        for (int k = 0; k < 16; k++)
            frame({1'b1, 11'(k * 211 + 1000), 4'(k)}, ~16'(k), -1, 1'b0, "R4", "R7");

        // R2: walking one through the data field, read back bit order
        for (int b = 0; b < 16; b++) begin
            frame(16'h7FF9, 16'(1) << b, -1, 1'b0, "R2", "R3");
            frame(16'h8009, 16'h0000, -1, 1'b0, "R2", "R7");
        end

        // R7: read frame carrying data must not write
        frame(16'h8006, 16'hBEEF, -1, 1'b0, "R7", "R7");
        frame(16'h8006, 16'h0000, -1, 1'b0, "R7", "R7");

        // R8/R9: sync cuts a write frame; register 3 must be unchanged
        begin
            int cuts [6] = '{0, 7, 15, 16, 23, 31};
            foreach (cuts[c]) begin
                frame(16'h0003, 16'hDEAD ^ 16'(cuts[c]), cuts[c], 1'b0, "R8",
                      cuts[c] == 31 ? "R9" : "R8");
                frame(16'h8003, 16'h0000, -1, 1'b1, cuts[c] == 31 ? "R9" : "R8", "R8");
            end
        end

        // R8: read frame cut mid-data; return line must drop, next frame normal
        frame(16'h8003, 16'h0000, 20, 1'b0, "R5", "R8");
        frame(16'h8004, 16'h0000, -1, 1'b1, "R8", "R8");

        // R10: data-line toggling with no sync
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(sdout_o == 1'b0, "R10", 32'(sdout_o), 32'd0);
            chk(wr_stb_o == 1'b0, "R10", 32'(wr_stb_o), 32'd0);
            sdin_i = 1'(((i * 7) >> 1) & 1);
        end
        sdin_i = 1'b0;
        for (int k = 0; k < 16; k++)
            frame(16'h8000 | 16'(k), 16'h0000, -1, 1'b0, "R10", "R10");

        // R5: final full readback of all registers
        for (int k = 0; k < 16; k++)
            frame(16'hFFF0 | 16'(k), 16'h5A5A, -1, 1'b0, "R5", "R7");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule